// File: doc/BRIEF.md
# Page Buffer Write Sequencer

This block is the write side of a byte-wide page-mode nonvolatile memory model. Bytes arrive one at a time and are collected in a 128-byte page buffer. While bytes keep coming, the page stays open. Once no byte has been loaded for a set number of clock cycles, the page closes. An internally timed commit cycle then writes the whole page into a behavioural storage array. During that cycle the block reports busy.

The byte-load port is a valid/ready stream. `wr_ready` is low exactly while `busy` is high. A beat is taken on a rising clock edge when `wr_valid` and `wr_ready` are both high and the enables allow a write. There is no queue: a beat offered while `wr_ready` is low is not stored. If the producer drops `wr_valid` before ready returns, that beat is lost.

The array keeps a full byte address. The upper address bits name the page and the lower seven bits name the column. All timing is counted in clock cycles set by parameters. The read port returns one byte, registered, one cycle after the request, and it refuses requests while the commit is running.

Top module: `pbw_page_writer`

## Requirements
- R1: After reset, `busy` and `rd_ok` are 0, `wr_ready` is 1, and every array byte reads as FFh.
- R2: Address bits 6..0 select the column inside a page, and bits ADDR_W-1..7 select the page. A byte committed from column c of page p is read back at address p*128+c.
- R3: A beat is loaded only when all of these hold at the clock edge: `wr_valid`=1, `wr_ready`=1, `chip_en`=1, `wr_en`=1 and `out_en`=0. Any other beat leaves the buffer and the array unchanged.
- R4: `busy` rises on the TIMEOUT_CYC-th clock edge after the edge that took the last beat, unless another beat is taken on one of those edges. A stream of beats spaced closer than that keeps the page open with no limit.
- R5: Loading the same column again while the page is open replaces the buffered byte, so the last value is the one committed.
- R6: The committed page is the page of the last beat taken. Earlier beats that named another page are committed at their column inside that last page.
- R7: Every column of the committed page that received no beat during the page load is written as FFh.
- R8: `busy` stays high for exactly COMMIT_CYC clock cycles. `wr_ready` equals the inverse of `busy`, and beats offered while busy are dropped.
- R9: A read request taken on a clock edge gives `rd_ok`=1 and the stored byte on `rd_data` after that edge when `busy` was 0. When `busy` was 1, it gives `rd_ok`=0 and `rd_data`=00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Byte-load beat present |
| wr_ready | output | 1 | Block can take a beat (not busy) |
| chip_en | input | 1 | Chip select, active high |
| wr_en | input | 1 | Write enable, active high |
| out_en | input | 1 | Output enable, active high; inhibits loads |
| wr_addr | input | ADDR_W | Byte address of the beat |
| wr_data | input | 8 | Byte value of the beat |
| busy | output | 1 | Internal commit cycle running |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read byte address |
| rd_ok | output | 1 | Read was served (registered) |
| rd_data | output | 8 | Read byte (registered) |

## Verification
A beat is taken on the edge that follows its drive. `busy` is due on the TIMEOUT_CYC-th edge after that and stays high for COMMIT_CYC edges. A read answer is due one edge after the request. The bench drives and samples only on falling edges. It counts falling edges from the one that follows the taking edge: it checks `busy` low after TIMEOUT_CYC-1 of them and high after one more. It then counts the falling edges at which `busy` is high and compares that count with COMMIT_CYC. Array contents are read back only after `busy` has fallen, and each one is compared with a shadow page built from the beats the bench expects to be taken.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
  localparam int COL_W      = 7;
  localparam int PAGE_BYTES = 1 << COL_W;
  localparam logic [7:0] ERASED = 8'hFF;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/pbw_load_timer.sv
module pbw_load_timer #(
  parameter int TIMEOUT_CYC = 40000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_fire,
  input  logic busy,
  output logic open_o,
  output logic close_o
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] idle_cnt;
  logic             open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      idle_cnt <= '0;
    end else if (load_fire) begin
      open_q   <= 1'b1;
      idle_cnt <= '0;
    end else if (open_q) begin
      if (idle_cnt == LAST) begin
        open_q   <= 1'b0;
        idle_cnt <= '0;
      end else begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end

  assign open_o  = open_q;
  assign close_o = open_q && !load_fire && (idle_cnt == LAST);

  // R4: page load and commit never overlap
  a_r4_open_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(open_q && busy));
endmodule

// File: rtl/pbw_page_buffer.sv
module pbw_page_buffer
  import pbw_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_fire,
  input  logic              first_load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  byte_t             ld_data,
  input  logic [COL_W-1:0]  rd_col,
  input  logic              busy,
  output byte_t             rd_byte,
  output logic [ADDR_W-COL_W-1:0] page_o
);
  localparam int PAGE_W = ADDR_W - COL_W;

  byte_t                 data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] loaded;
  logic [PAGE_W-1:0]     page_q;
  logic [COL_W-1:0]      ld_col;

  assign ld_col = ld_addr[COL_W-1:0];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_col
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        loaded[g] <= 1'b0;
      end else if (load_fire) begin
        if (ld_col == COL_W'(g))
          loaded[g] <= 1'b1;
        else if (first_load)
          loaded[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (load_fire && (ld_col == COL_W'(g)))
        data_q[g] <= ld_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      page_q <= '0;
    else if (load_fire)
      page_q <= ld_addr[ADDR_W-1:COL_W];
  end

  assign rd_byte = loaded[rd_col] ? data_q[rd_col] : ERASED;
  assign page_o  = page_q;

  // R8: nothing in the buffer moves while the commit runs
  a_r8_buffer_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(loaded) && $stable(page_q)));
endmodule

// File: rtl/pbw_commit.sv
module pbw_commit
  import pbw_pkg::*;
#(
  parameter int PAGE_W     = 4,
  parameter int COMMIT_CYC = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAGE_W-1:0] page_i,
  input  byte_t             byte_i,
  output logic [COL_W-1:0]  col_o,
  output logic              busy_o,
  output logic              arr_we,
  output logic [PAGE_W+COL_W-1:0] arr_addr,
  output byte_t             arr_wdata
);
  localparam int RAW_W = $clog2(COMMIT_CYC + 1);
  localparam int CYC_W = (RAW_W > COL_W + 1) ? RAW_W : COL_W + 1;
  localparam logic [CYC_W-1:0] LAST = CYC_W'(COMMIT_CYC - 1);

  logic [CYC_W-1:0] cyc;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cyc    <= '0;
    end else if (busy_q) begin
      if (cyc == LAST) begin
        busy_q <= 1'b0;
        cyc    <= '0;
      end else begin
        cyc <= cyc + 1'b1;
      end
    end else if (start) begin
      busy_q <= 1'b1;
      cyc    <= '0;
    end
  end

  assign col_o     = cyc[COL_W-1:0];
  assign busy_o    = busy_q;
  assign arr_we    = busy_q && (cyc < CYC_W'(PAGE_BYTES));
  assign arr_addr  = {page_i, col_o};
  assign arr_wdata = byte_i;

  // R8: a running commit is never restarted
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !start);
endmodule

// File: rtl/pbw_store.sv
module pbw_store
  import pbw_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  byte_t             wdata,
  input  logic              rd_en,
  input  logic              busy,
  input  logic [ADDR_W-1:0] raddr,
  output logic              rd_ok,
  output byte_t             rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  byte_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ok   <= 1'b0;
      rd_data <= '0;
    end else if (rd_en && !busy) begin
      rd_ok   <= 1'b1;
      rd_data <= mem[raddr];
    end else begin
      rd_ok   <= 1'b0;
      rd_data <= '0;
    end
  end
endmodule

// File: rtl/pbw_page_writer.sv
module pbw_page_writer
  import pbw_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int TIMEOUT_CYC = 40000,
  parameter int COMMIT_CYC  = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              chip_en,
  input  logic              wr_en,
  input  logic              out_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              busy,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_ok,
  output logic [7:0]        rd_data
);
  localparam int PAGE_W = ADDR_W - COL_W;

  logic              load_fire, page_open, close_pulse, busy_w;
  logic [COL_W-1:0]  commit_col;
  logic [PAGE_W-1:0] buf_page;
  byte_t             buf_byte, arr_wdata;
  logic              arr_we;
  logic [ADDR_W-1:0] arr_addr;

  assign wr_ready  = !busy_w;
  assign load_fire = wr_valid && wr_ready && chip_en && wr_en && !out_en;
  assign busy      = busy_w;

  pbw_load_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_fire(load_fire), .busy(busy_w),
    .open_o(page_open), .close_o(close_pulse)
  );

  pbw_page_buffer #(.ADDR_W(ADDR_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .load_fire(load_fire), .first_load(!page_open),
    .ld_addr(wr_addr), .ld_data(wr_data), .rd_col(commit_col), .busy(busy_w),
    .rd_byte(buf_byte), .page_o(buf_page)
  );

  pbw_commit #(.PAGE_W(PAGE_W), .COMMIT_CYC(COMMIT_CYC)) u_commit (
    .clk(clk), .rst_n(rst_n), .start(close_pulse), .page_i(buf_page),
    .byte_i(buf_byte), .col_o(commit_col), .busy_o(busy_w),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
  );

  pbw_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr(arr_addr), .wdata(arr_wdata),
    .rd_en(rd_en), .busy(busy_w), .raddr(rd_addr),
    .rd_ok(rd_ok), .rd_data(rd_data)
  );

  // R4: a commit only begins out of an open page load
  a_r4_busy_from_open: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_w) |-> $past(page_open));
endmodule

// File: tb/pbw_page_writer_test.sv
module pbw_page_writer_test;
  localparam int AW = 11;
  localparam int TO = 8;
  localparam int CC = 140;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 0, chip_en = 0, wr_en = 0, out_en = 0, rd_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic wr_ready, busy, rd_ok;
  logic [7:0] rd_data;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  logic [7:0] shadow [0:(1<<AW)-1];
  logic [7:0] bf_data [0:127];
  bit         bf_set  [0:127];
  bit         bf_open = 0;
  logic [AW-8:0] bf_page = '0;

  localparam logic [18:0] VEC [10] = '{
    {11'h105, 8'h5A}, {11'h180, 8'h11}, {11'h181, 8'h22}, {11'h1FF, 8'h7F},
    {11'h1C0, 8'h40}, {11'h181, 8'hB2}, {11'h190, 8'h90}, {11'h191, 8'h91},
    {11'h182, 8'h00}, {11'h1FE, 8'hEE}
  };

  pbw_page_writer #(.ADDR_W(AW), .TIMEOUT_CYC(TO), .COMMIT_CYC(CC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .chip_en(chip_en), .wr_en(wr_en), .out_en(out_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_ok(rd_ok), .rd_data(rd_data)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  // drive one beat for one cycle; bench predicts acceptance from R3/R8
  task automatic load(input logic [AW-1:0] a, input logic [7:0] d,
                      input logic ce, input logic we, input logic oe);
    bit take;
    take = ce && we && !oe && !busy;
    wr_valid = 1; chip_en = ce; wr_en = we; out_en = oe;
    wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 0; chip_en = 0; wr_en = 0; out_en = 0;
    if (take) begin
      if (!bf_open) for (int i = 0; i < 128; i++) bf_set[i] = 0;
      bf_open = 1;
      bf_data[a[6:0]] = d;
      bf_set[a[6:0]] = 1;
      bf_page = a[AW-1:7];
    end
  endtask

  task automatic rd(input logic [AW-1:0] a);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic model_commit();
    for (int i = 0; i < 128; i++)
      shadow[{bf_page, 7'(i)}] = bf_set[i] ? bf_data[i] : 8'hFF;
    bf_open = 0;
  endtask

  task automatic wait_commit();
    for (int i = 0; i < TO + 4 && !busy; i++) @(negedge clk);
    for (int i = 0; i < CC + 4 && busy; i++) @(negedge clk);
    model_commit();
  endtask

  task automatic check_read(input string req, input logic [AW-1:0] a);
    rd(a);
    check(req, rd_ok, 1);
    check(req, rd_data, shadow[a]);
  endtask

  initial begin
    int n;
    for (int i = 0; i < (1<<AW); i++) shadow[i] = 8'hFF;
    for (int i = 0; i < 128; i++) begin bf_set[i] = 0; bf_data[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 ready", wr_ready, 1);
    check("R1 rd_ok", rd_ok, 0);
    check_read("R1 erased", 11'h333);

    // table walk: R2 R5 R6 R7 (first beat names page 2, rest page 3)
    for (int v = 0; v < 10; v++) load(VEC[v][18:8], VEC[v][7:0], 1, 1, 0);
    wait_commit();
    for (int c = 0; c < 128; c++) check_read("R7 page fill", {4'd3, 7'(c)});
    check_read("R6 last page wins", 11'h105);
    rd(11'h185); check("R6 col of earlier beat", rd_data, 8'h5A);
    rd(11'h181); check("R5 overwrite", rd_data, 8'hB2);
    rd(11'h1FF); check("R2 column 7F", rd_data, 8'h7F);

    // R4 exact timeout edge, R8 busy length and ready
    load(11'h205, 8'hC3, 1, 1, 0);
    repeat (TO - 1) @(negedge clk);
    check("R4 still open", busy, 0);
    @(negedge clk);
    check("R4 busy rises", busy, 1);
    check("R8 ready low", wr_ready, 0);
    n = 0;
    for (int i = 0; i < CC + 10 && busy; i++) begin n++; @(negedge clk); end
    check("R8 busy length", n, CC);
    check("R8 ready back", wr_ready, 1);
    model_commit();
    check_read("R4 commit", 11'h205);

    // R4 open indefinitely with gaps of TO-1 edges
    load(11'h280, 8'h01, 1, 1, 0);
    for (int k = 0; k < 6; k++) begin
      repeat (TO - 2) @(negedge clk);
      check("R4 kept open", busy, 0);
      load(11'h280 + 11'(k + 1), 8'(8'h10 + k), 1, 1, 0);
    end
    wait_commit();
    for (int c = 0; c < 8; c++) check_read("R4 burst data", 11'h280 + 11'(c));

    // R8 beat dropped while busy, R9 read refused while busy
    load(11'h300, 8'hAB, 1, 1, 0);
    for (int i = 0; i < TO + 4 && !busy; i++) @(negedge clk);
    load(11'h301, 8'hCD, 1, 1, 0);
    rd(11'h205);
    check("R9 refused", rd_ok, 0);
    check("R9 zero data", rd_data, 0);
    for (int i = 0; i < CC + 4 && busy; i++) @(negedge clk);
    model_commit();
    check_read("R8 dropped beat", 11'h301);
    check_read("R8 kept beat", 11'h300);

    // R3 inhibits
    load(11'h381, 8'h11, 1, 1, 1);
    load(11'h382, 8'h22, 0, 1, 0);
    load(11'h383, 8'h33, 1, 0, 0);
    load(11'h384, 8'h44, 1, 1, 0);
    wait_commit();
    check_read("R3 oe inhibit", 11'h381);
    check_read("R3 ce inhibit", 11'h382);
    check_read("R3 we inhibit", 11'h383);
    check_read("R3 taken", 11'h384);
    // R3: valid low never loads
    wr_en = 1; chip_en = 1; wr_addr = 11'h390; wr_data = 8'h55;
    repeat (TO + 3) @(negedge clk);
    check("R3 no valid no busy", busy, 0);
    wr_en = 0; chip_en = 0;

    finish_run();
  end
endmodule